// File: doc/BRIEF.md
# UART Packet Framing Assembler

This block sits behind a UART receiver and turns its byte stream into fixed-width parameter words. Every byte arrives with a one-cycle strobe. While hunting, the block throws bytes away until it sees a configurable start tag. It then collects exactly seven six-byte groups, a 42-byte sequence, and goes back to hunting. Each complete group becomes one 48-bit word. The first byte of a group sits in the top byte lane, so each word is big-endian.

Each finished word is written into a small synchronous FIFO. A downstream consumer pops the FIFO whenever it wants a word. The FIFO raises an almost-full flag so that the sender can hold back before the buffer runs out of room. If a word completes while the FIFO is full and nothing is popped in that cycle, the word is lost and a sticky overflow flag records the loss. A one-cycle pulse marks the end of each 42-byte sequence. The block never looks at the meaning of the words it carries.

Top module: `uart_pkt_framer`

## Requirements
- R1: After a synchronous reset, `fifo_empty` is 1 and `fifo_afull`, `overflow` and `seq_done` are 0. The block is hunting for the start tag.
- R2: While hunting, a strobed byte that differs from `START_TAG` (default 8'hA5) writes nothing to the FIFO and does not start a sequence.
- R3: After the tag, six strobed bytes form one 48-bit word. The first byte lands in bits [47:40] and the sixth in bits [7:0]. The tag byte itself is not stored.
- R4: Whenever `fifo_empty` is 0, `pkt_data` shows the oldest stored word. Words leave in the order they were written. A `pop` in a cycle where the FIFO is empty has no effect.
- R5: After 42 data bytes the block returns to hunting, and later non-tag bytes are ignored. A byte equal to the tag that arrives inside a sequence is treated as ordinary data.
- R6: `seq_done` is high for exactly one cycle, in the cycle after the seventh word of a sequence completes. This holds whether that word was stored or dropped.
- R7: `fifo_afull` is 1 exactly when the FIFO holds at least `DEPTH - AFULL_MARGIN` words. With the defaults this is 6 of 8.
- R8: A word that completes while the FIFO holds `DEPTH` words, with no `pop` in the same cycle, is dropped. The stored contents stay unchanged, and `overflow` becomes 1 and stays 1 until reset. A word that completes on a full FIFO in the same cycle as a `pop` is stored.
- R9: In a cycle where `byte_valid` is 0, the value on `byte_data` has no effect, even when it equals the tag.
- R10: A reset in the middle of a sequence discards the partial word, the stored words and the overflow flag. Bytes that follow the reset without a new tag are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | One-cycle strobe marking a received byte |
| byte_data | input | 8 | Received byte |
| pop | input | 1 | Consumer removes the head word |
| pkt_data | output | 48 | Head word of the FIFO, valid while not empty |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_afull | output | 1 | FIFO occupancy has reached the almost-full level |
| overflow | output | 1 | Sticky flag: a word was dropped |
| seq_done | output | 1 | One-cycle pulse at the end of a 42-byte sequence |

## Verification
The assertions assume that every input carries a known 0 or 1 in every cycle after reset. They also assume that `AFULL_MARGIN` lies between 1 and `DEPTH - 1`, so that an almost-full FIFO is never empty. The bench drives only defined values and keeps the default parameters. It applies pops in regular patterns, which include pops while the FIFO is empty and pops in the same cycle a word completes on a full FIFO. A behavioural queue model checks every output on every clock, and targeted checks cover tag hunting, tag bytes inside a sequence, overflow and reset in the middle of a sequence.

// File: rtl/uart_pkt_framer.sv
module uart_pkt_framer #(
  parameter logic [7:0] START_TAG     = 8'hA5,
  parameter int         BYTES_PER_PKT = 6,
  parameter int         PKTS_PER_SEQ  = 7,
  parameter int         DEPTH         = 8,
  parameter int         AFULL_MARGIN  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       byte_valid,
  input  logic [7:0]                 byte_data,
  input  logic                       pop,
  output logic [8*BYTES_PER_PKT-1:0] pkt_data,
  output logic                       fifo_empty,
  output logic                       fifo_afull,
  output logic                       overflow,
  output logic                       seq_done
);

  localparam int WORD_W = 8 * BYTES_PER_PKT;
  localparam int BCW    = (BYTES_PER_PKT > 1) ? $clog2(BYTES_PER_PKT) : 1;
  localparam int PCW    = (PKTS_PER_SEQ > 1) ? $clog2(PKTS_PER_SEQ) : 1;
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW     = AW + 1;

  logic              capturing;
  logic [BCW-1:0]    byte_cnt;
  logic [PCW-1:0]    pkt_cnt;
  logic [WORD_W-9:0] shreg;
  logic [WORD_W-1:0] assm;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;

  logic take, word_done, last_word, full, pop_ok, push;

  assign take      = capturing && byte_valid;
  assign assm      = {shreg, byte_data};
  assign word_done = take && (byte_cnt == BCW'(BYTES_PER_PKT - 1));
  assign last_word = word_done && (pkt_cnt == PCW'(PKTS_PER_SEQ - 1));
  assign full      = (count == CW'(DEPTH));
  assign pop_ok    = pop && (count != '0);
  assign push      = word_done && (!full || pop_ok);

  assign pkt_data   = mem[rd_ptr];
  assign fifo_empty = (count == '0);
  assign fifo_afull = (count >= CW'(DEPTH - AFULL_MARGIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      capturing <= 1'b0;
      byte_cnt  <= '0;
      pkt_cnt   <= '0;
      shreg     <= '0;
      seq_done  <= 1'b0;
    end else begin
      seq_done <= last_word;
      if (!capturing) begin
        if (byte_valid && byte_data == START_TAG) begin
          capturing <= 1'b1;
          byte_cnt  <= '0;
          pkt_cnt   <= '0;
        end
      end else if (byte_valid) begin
        shreg <= assm[WORD_W-9:0];
        if (word_done) begin
          byte_cnt <= '0;
          if (last_word) begin
            capturing <= 1'b0;
            pkt_cnt   <= '0;
          end else begin
            pkt_cnt <= pkt_cnt + 1'b1;
          end
        end else begin
          byte_cnt <= byte_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= assm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push)
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop_ok);
      if (word_done && !push) overflow <= 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (fifo_empty && !overflow && !seq_done && !capturing));

  p_idle_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (!capturing && byte_valid && byte_data != START_TAG) |=> (!capturing && count <= $past(count)));

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && pop && !word_done) |=> fifo_empty);

  p_seq_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);

  p_seq_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> !capturing);

  p_afull_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_afull |-> !fifo_empty);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_drop_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (full && word_done && !pop) |=> (full && overflow && $stable(rd_ptr)));

endmodule

// File: tb/test_uart_pkt_framer.sv
module test_uart_pkt_framer;
  localparam logic [7:0] TAG = 8'hA5;
  localparam int DEPTH = 8;
  localparam int MARGIN = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic pop = 1'b0;
  logic [47:0] pkt_data;
  logic fifo_empty, fifo_afull, overflow, seq_done;

  always #5 clk = ~clk;

  uart_pkt_framer #(.START_TAG(TAG), .BYTES_PER_PKT(6), .PKTS_PER_SEQ(7),
                    .DEPTH(DEPTH), .AFULL_MARGIN(MARGIN)) i_uart_pkt_framer (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data), .pop(pop),
    .pkt_data(pkt_data), .fifo_empty(fifo_empty), .fifo_afull(fifo_afull),
    .overflow(overflow), .seq_done(seq_done));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_cap = 0, m_bc = 0, m_pc = 0;
  logic [47:0] m_word = '0;
  logic [47:0] q[$];
  bit m_ovf = 0, m_done = 0;

  int tick_no = 0;
  int pop_mode = 0;

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (tick %0d)", req, act, exp, tick_no);
    end
  endtask

  task automatic model(input bit v, input logic [7:0] d, input bit p, input bit r);
    bit do_pop, full_before;
    if (r) begin
      m_cap = 0; m_bc = 0; m_pc = 0; m_word = '0;
      q.delete(); m_ovf = 0; m_done = 0;
      return;
    end
    m_done = 0;
    do_pop = p && q.size() > 0;
    full_before = (q.size() == DEPTH);
    if (do_pop) void'(q.pop_front());
    if (v) begin
      if (m_cap == 0) begin
        if (d == TAG) begin m_cap = 1; m_bc = 0; m_pc = 0; end
      end else begin
        m_word = {m_word[39:0], d};
        if (m_bc == 5) begin
          m_bc = 0;
          if (!full_before || do_pop) q.push_back(m_word);
          else m_ovf = 1;
          m_pc++;
          if (m_pc == 7) begin m_cap = 0; m_pc = 0; m_done = 1; end
        end else begin
          m_bc++;
        end
      end
    end
  endtask

  task automatic compare();
    chk("R4 empty", 48'(fifo_empty), 48'(q.size() == 0));
    if (q.size() > 0) chk("R3/R4 head word", pkt_data, q[0]);
    chk("R7 afull", 48'(fifo_afull), 48'(q.size() >= DEPTH - MARGIN));
    chk("R8 overflow", 48'(overflow), 48'(m_ovf));
    chk("R6 seq_done", 48'(seq_done), 48'(m_done));
  endtask

  task automatic tick(input bit v, input logic [7:0] d, input bit r);
    bit p;
    case (pop_mode)
      0: p = 0;
      1: p = (tick_no % 3 == 0);
      default: p = 1;
    endcase
    byte_valid = v; byte_data = d; pop = p; rst = r;
    model(v, d, p, r);
    @(posedge clk);
    @(negedge clk);
    tick_no++;
    compare();
  endtask

  task automatic send(input logic [7:0] d);
    tick(1, d, 0);
    tick(0, ~d, 0);
  endtask

  task automatic send_seq(input logic [7:0] base);
    send(TAG);
    for (int i = 0; i < 42; i++) send(8'(base + i));
  endtask

  initial begin
    @(negedge clk);
    tick(0, 0, 1);
    tick(0, 0, 1);
    chk("R1 empty after reset", 48'(fifo_empty), 48'd1);
    chk("R1 flags after reset", {45'd0, fifo_afull, overflow, seq_done}, 48'd0);

    send(8'h00); send(8'h5A); send(8'hFF); send(8'hA4);
    for (int i = 0; i < 6; i++) send(8'h11);
    chk("R2 idle bytes ignored", 48'(fifo_empty), 48'd1);

    for (int i = 0; i < 3; i++) tick(0, TAG, 0);
    for (int i = 0; i < 6; i++) send(8'h22);
    chk("R9 unstrobed tag ignored", 48'(fifo_empty), 48'd1);

    send(TAG);
    for (int i = 1; i <= 6; i++) send(8'(i));
    chk("R3 first word", pkt_data, 48'h010203040506);
    for (int i = 7; i <= 41; i++) send(8'(i));
    tick(1, 8'd42, 0);
    chk("R6 seq_done pulse", 48'(seq_done), 48'd1);
    tick(0, 0, 0);
    chk("R6 seq_done one cycle", 48'(seq_done), 48'd0);
    chk("R7 afull at seven", 48'(fifo_afull), 48'd1);

    pop_mode = 2;
    for (int i = 0; i < 10; i++) tick(0, 0, 0);
    pop_mode = 0;
    chk("R4 drained", 48'(fifo_empty), 48'd1);
    for (int i = 0; i < 8; i++) send(8'h33);
    chk("R5 back to hunting", 48'(fifo_empty), 48'd1);

    send(TAG);
    for (int i = 0; i < 42; i++) send((i % 5 == 0) ? TAG : 8'(8'h40 + i));
    chk("R5 tag inside data", pkt_data, {TAG, 8'h41, 8'h42, 8'h43, 8'h44, TAG});

    pop_mode = 1;
    for (int i = 0; i < 30; i++) tick(0, 0, 0);
    pop_mode = 0;

    send_seq(8'h80);
    send_seq(8'hC0);
    chk("R8 overflow set", 48'(overflow), 48'd1);
    for (int i = 0; i < 5; i++) send(8'h77);
    chk("R8 overflow sticky", 48'(overflow), 48'd1);

    pop_mode = 1;
    send_seq(8'h10);
    pop_mode = 2;
    for (int i = 0; i < 12; i++) tick(0, 0, 0);

    pop_mode = 0;
    send(TAG); send(8'h01); send(8'h02); send(8'h03);
    tick(0, 0, 1);
    for (int i = 0; i < 6; i++) send(8'h55);
    chk("R10 reset mid sequence empty", 48'(fifo_empty), 48'd1);
    chk("R10 reset clears overflow", 48'(overflow), 48'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule